// File: doc/BRIEF.md
# Multi-Lane SPI Lane Mask and Routing Unit

This unit sits beside the serializers of an SPI controller that has several physical data lanes. It keeps two lane-enable masks, one for the receive inputs and one for the transmit outputs. It also keeps a table that steers each logical peripheral lane onto a physical controller lane. Its outputs drive the serializers' lane enables directly. Receive data from a disabled physical lane never reaches a logical lane. A disabled transmit lane is driven to a fixed idle level.

Software fills the lane table. Command writes load the masks. A striped transfer, where each lane carries its own word, is bracketed by two sequence strobes. The start strobe opens every mapped lane, up to the active lane count. The end strobe returns both masks to the single lane that logical lane 0 maps to. A setup strobe does the same return when the controller has more than one lane. A mask change never takes effect while chip select is asserted: it waits until the transfer ends. A constant capability word reports the lane count and the data width.

Top module: `lane_route_unit`

## Requirements
- R1: After reset both masks read 8'h01, logical lane i maps to physical lane i, and the error flag is 0.
- R2: A command write to register 4'h3 loads the receive mask, and a write to 4'h4 loads the transmit mask. The new value is visible after the next clock edge. A write to any other register number changes neither mask.
- R3: A mask write with any bit set at or above NUM_LANES sets the error flag and leaves that mask unchanged.
- R4: A table write with a legal lane index and a legal physical lane updates that one entry. If either value is at or above NUM_LANES, the write sets the error flag and leaves the table unchanged.
- R5: The error flag stays set until reset.
- R6: A mask update requested while chip select is active is held pending. It is applied at the first clock edge at which chip select is sampled inactive. A later request overwrites an earlier pending one.
- R7: A new request in a given cycle beats a pending value released in that same cycle, and the pending value is discarded. For a given mask, a command write beats a sequence strobe in the same cycle.
- R8: The stripe-start strobe loads both masks with the OR of (1 << map[i]) for every logical lane i below the active lane count. The stripe-end strobe loads both masks with (1 << map[0]).
- R9: The setup strobe loads both masks with (1 << map[0]) when NUM_LANES > 1.
- R10: Logical receive lane i outputs physical input map[i] when receive-mask bit map[i] is set, and 0 otherwise.
- R11: Physical transmit lane p outputs the lowest-numbered logical lane mapped to p when transmit-mask bit p is set. If that mask bit is clear, or no logical lane maps to p, it outputs TX_IDLE (0 by default).
- R12: The capability word is {8'h00, lane count[7:0], data width[15:0]}, which is 32'h0004_0020 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_reg_i | input | 4 | Command register number |
| cmd_data_i | input | MASK_W | Command write data |
| map_wr_i | input | 1 | Lane table write strobe |
| map_lane_i | input | IDX_W | Logical lane index to write |
| map_phys_i | input | IDX_W | Physical lane for that logical lane |
| act_cnt_i | input | CNT_W | Active lane count used by stripe-start |
| setup_i | input | 1 | Setup strobe |
| stripe_start_i | input | 1 | Start-of-striped-transfer strobe |
| stripe_end_i | input | 1 | End-of-striped-transfer strobe |
| cs_active_i | input | 1 | Chip select asserted |
| phys_rx_i | input | NUM_LANES | Receive bits from the physical lanes |
| log_tx_i | input | NUM_LANES | Transmit bits from the logical lanes |
| log_rx_o | output | NUM_LANES | Receive bits steered to the logical lanes |
| phys_tx_o | output | NUM_LANES | Transmit bits steered to the physical lanes |
| sdi_mask_o | output | MASK_W | Receive lane mask |
| sdo_mask_o | output | MASK_W | Transmit lane mask |
| map_o | output | NUM_LANES*IDX_W | Lane table; entry i is at bits [i*IDX_W +: IDX_W] |
| cap_o | output | 32 | Capability word |
| err_o | output | 1 | Sticky error flag |

## Verification
Two situations put two functions in the same cycle.

The first is a chip-select release that frees a pending mask while a new command write for the same mask arrives. The bench first builds a pending value under an active chip select. It then drops chip select in the same cycle as a second write. It expects the second write's value after the edge, and again one cycle later, which shows the stale pending value was discarded.

The second is a command write and a stripe-end strobe in the same cycle. Here the written mask must take the written value, while the other mask takes the primary-lane value.

// File: rtl/lane_route_pkg.sv
package lane_route_pkg;
  typedef enum logic [3:0] {
    CMD_RX_MASK = 4'h3,
    CMD_TX_MASK = 4'h4
  } cmd_reg_e;

  localparam logic [7:0] CAP_REG_OFFSET = 8'h0C;
endpackage

// File: rtl/lane_map_regs.sv
module lane_map_regs #(
  parameter int NUM_LANES = 4,
  parameter int MASK_W    = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              map_wr_i,
  input  logic [IDX_W-1:0]                  map_lane_i,
  input  logic [IDX_W-1:0]                  map_phys_i,
  input  logic [CNT_W-1:0]                  act_cnt_i,
  output logic [NUM_LANES-1:0][IDX_W-1:0]   map_o,
  output logic                              map_err_o,
  output logic [MASK_W-1:0]                 prim_mask_o,
  output logic [MASK_W-1:0]                 all_mask_o
);
  logic [NUM_LANES-1:0][IDX_W-1:0] map_q;
  logic legal;

  assign legal     = (int'(map_lane_i) < NUM_LANES) && (int'(map_phys_i) < NUM_LANES);
  assign map_err_o = map_wr_i && !legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LANES; i++) map_q[i] <= IDX_W'(i);
    end else if (map_wr_i && legal) begin
      for (int i = 0; i < NUM_LANES; i++)
        if (map_lane_i == IDX_W'(i)) map_q[i] <= map_phys_i;
    end
  end

  always_comb begin
    prim_mask_o = MASK_W'(1) << map_q[0];
    all_mask_o  = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (i < int'(act_cnt_i)) all_mask_o |= MASK_W'(1) << map_q[i];
  end

  assign map_o = map_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_map_chk
    assert_map_entry_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(map_q[g]) < NUM_LANES);
  end

  assert_bad_map_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_err_o |=> $stable(map_q));
endmodule

// File: rtl/lane_mask_chan.sv
module lane_mask_chan
  import lane_route_pkg::*;
#(
  parameter int         NUM_LANES = 4,
  parameter int         MASK_W    = 8,
  parameter logic [3:0] CMD_ADDR  = 4'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [3:0]        cmd_reg_i,
  input  logic [MASK_W-1:0] cmd_data_i,
  input  logic              setup_i,
  input  logic              stripe_start_i,
  input  logic              stripe_end_i,
  input  logic              cs_active_i,
  input  logic [MASK_W-1:0] prim_mask_i,
  input  logic [MASK_W-1:0] all_mask_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              err_o
);
  localparam logic [MASK_W-1:0] LEGAL_BITS = MASK_W'((64'd1 << NUM_LANES) - 64'd1);

  logic [MASK_W-1:0] mask_q, pend_q, req_d;
  logic              pend_v_q, req_v, hit, legal, setup_hit;

  if (NUM_LANES > 1) begin : g_multi
    assign setup_hit = setup_i;
  end else begin : g_single
    assign setup_hit = 1'b0;
  end

  assign hit   = cmd_wr_i && (cmd_reg_i == CMD_ADDR);
  assign legal = ~|(cmd_data_i & ~LEGAL_BITS);
  assign err_o = hit && !legal;

  // command write > primary restore > all-lanes open
  always_comb begin
    req_v = 1'b1;
    req_d = '0;
    if (hit && legal)                    req_d = cmd_data_i;
    else if (stripe_end_i || setup_hit)  req_d = prim_mask_i;
    else if (stripe_start_i)             req_d = all_mask_i;
    else                                 req_v = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= MASK_W'(1);
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (req_v) begin
      if (cs_active_i) begin
        pend_q   <= req_d;
        pend_v_q <= 1'b1;
      end else begin
        mask_q   <= req_d;
        pend_v_q <= 1'b0;
      end
    end else if (pend_v_q && !cs_active_i) begin
      mask_q   <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  assign mask_o = mask_q;

  assert_mask_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ~|(mask_q & ~LEGAL_BITS));

  assert_mask_cs_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_q) |-> !$past(cs_active_i));
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int   NUM_LANES = 4,
  parameter int   IDX_W     = 3,
  parameter logic TX_IDLE   = 1'b0
) (
  input  logic [NUM_LANES-1:0][IDX_W-1:0] map_i,
  input  logic [NUM_LANES-1:0]            sdi_en_i,
  input  logic [NUM_LANES-1:0]            sdo_en_i,
  input  logic [NUM_LANES-1:0]            phys_rx_i,
  input  logic [NUM_LANES-1:0]            log_tx_i,
  output logic [NUM_LANES-1:0]            log_rx_o,
  output logic [NUM_LANES-1:0]            phys_tx_o
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_rx
    logic [NUM_LANES-1:0] rx_sh, en_sh;
    always_comb begin
      rx_sh       = phys_rx_i >> map_i[i];
      en_sh       = sdi_en_i >> map_i[i];
      log_rx_o[i] = rx_sh[0] & en_sh[0];
    end
  end

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_tx
    logic found, val;
    always_comb begin
      found = 1'b0;
      val   = TX_IDLE;
      // descending scan: lowest logical lane wins
      for (int i = NUM_LANES - 1; i >= 0; i--) begin
        if (map_i[i] == IDX_W'(p)) begin
          found = 1'b1;
          val   = log_tx_i[i];
        end
      end
      phys_tx_o[p] = (sdo_en_i[p] && found) ? val : TX_IDLE;
    end
  end
endmodule

// File: rtl/lane_route_unit.sv
module lane_route_unit
  import lane_route_pkg::*;
#(
  parameter int   NUM_LANES = 4,
  parameter int   MASK_W    = 8,
  parameter int   DATA_W    = 32,
  parameter logic TX_IDLE   = 1'b0,
  localparam int  IDX_W     = $clog2(NUM_LANES) + 1,
  localparam int  CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_wr_i,
  input  logic [3:0]                 cmd_reg_i,
  input  logic [MASK_W-1:0]          cmd_data_i,
  input  logic                       map_wr_i,
  input  logic [IDX_W-1:0]           map_lane_i,
  input  logic [IDX_W-1:0]           map_phys_i,
  input  logic [CNT_W-1:0]           act_cnt_i,
  input  logic                       setup_i,
  input  logic                       stripe_start_i,
  input  logic                       stripe_end_i,
  input  logic                       cs_active_i,
  input  logic [NUM_LANES-1:0]       phys_rx_i,
  input  logic [NUM_LANES-1:0]       log_tx_i,
  output logic [NUM_LANES-1:0]       log_rx_o,
  output logic [NUM_LANES-1:0]       phys_tx_o,
  output logic [MASK_W-1:0]          sdi_mask_o,
  output logic [MASK_W-1:0]          sdo_mask_o,
  output logic [NUM_LANES*IDX_W-1:0] map_o,
  output logic [31:0]                cap_o,
  output logic                       err_o
);
  localparam logic [31:0] CAP_WORD = {8'h00, 8'(NUM_LANES), 16'(DATA_W)};
  localparam logic [1:0][3:0] CHAN_ADDR = {CMD_TX_MASK, CMD_RX_MASK};

  logic [NUM_LANES-1:0][IDX_W-1:0] map;
  logic [MASK_W-1:0]               prim_mask, all_mask;
  logic [1:0][MASK_W-1:0]          chan_mask;
  logic [1:0]                      chan_err;
  logic                            map_err, err_q;

  lane_map_regs #(
    .NUM_LANES(NUM_LANES), .MASK_W(MASK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_map (
    .clk_i, .rst_ni, .map_wr_i, .map_lane_i, .map_phys_i, .act_cnt_i,
    .map_o(map), .map_err_o(map_err),
    .prim_mask_o(prim_mask), .all_mask_o(all_mask)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    lane_mask_chan #(
      .NUM_LANES(NUM_LANES), .MASK_W(MASK_W), .CMD_ADDR(CHAN_ADDR[c])
    ) u_chan (
      .clk_i, .rst_ni, .cmd_wr_i, .cmd_reg_i, .cmd_data_i,
      .setup_i, .stripe_start_i, .stripe_end_i, .cs_active_i,
      .prim_mask_i(prim_mask), .all_mask_i(all_mask),
      .mask_o(chan_mask[c]), .err_o(chan_err[c])
    );
  end

  lane_steer #(
    .NUM_LANES(NUM_LANES), .IDX_W(IDX_W), .TX_IDLE(TX_IDLE)
  ) u_steer (
    .map_i(map),
    .sdi_en_i(chan_mask[0][NUM_LANES-1:0]),
    .sdo_en_i(chan_mask[1][NUM_LANES-1:0]),
    .phys_rx_i, .log_tx_i, .log_rx_o, .phys_tx_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | map_err | (|chan_err);
  end

  assign sdi_mask_o = chan_mask[0];
  assign sdo_mask_o = chan_mask[1];
  assign map_o      = map;
  assign cap_o      = CAP_WORD;
  assign err_o      = err_q;

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  assert_err_on_bad_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_err |=> err_q);
endmodule

// File: tb/lane_route_unit_bench.sv
module lane_route_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [3:0] cmd_reg_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic       map_wr_i = 1'b0;
  logic [2:0] map_lane_i = '0, map_phys_i = '0;
  logic [2:0] act_cnt_i = 3'd4;
  logic       setup_i = 1'b0, stripe_start_i = 1'b0, stripe_end_i = 1'b0, cs_active_i = 1'b0;
  logic [3:0] phys_rx_i = '0, log_tx_i = '0, log_rx_o, phys_tx_o;
  logic [7:0] sdi_mask_o, sdo_mask_o;
  logic [11:0] map_o;
  logic [31:0] cap_o;
  logic       err_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  lane_route_unit u_lane_route_unit (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cmd_wr_i = 0; map_wr_i = 0; setup_i = 0;
    stripe_start_i = 0; stripe_end_i = 0; cs_active_i = 0; act_cnt_i = 3'd4;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic wr(logic [3:0] r, logic [7:0] d);
    cmd_wr_i = 1; cmd_reg_i = r; cmd_data_i = d;
    step();
    cmd_wr_i = 0;
  endtask

  task automatic wmap(logic [2:0] l, logic [2:0] p);
    map_wr_i = 1; map_lane_i = l; map_phys_i = p;
    step();
    map_wr_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sdi", sdi_mask_o, 8'h01);
    chk("R1 sdo", sdo_mask_o, 8'h01);
    chk("R1 map", map_o, 12'h688);
    chk("R1 err", err_o, 0);
    chk("R12 cap", cap_o, 32'h0004_0020);
  endtask

  task automatic t_mask_write();
    do_reset();
    wr(4'h3, 8'h0A);
    chk("R2 sdi", sdi_mask_o, 8'h0A);
    chk("R2 sdo untouched", sdo_mask_o, 8'h01);
    wr(4'h4, 8'h05);
    chk("R2 sdo", sdo_mask_o, 8'h05);
    wr(4'h5, 8'h0F);
    chk("R2 other reg sdi", sdi_mask_o, 8'h0A);
    chk("R2 other reg sdo", sdo_mask_o, 8'h05);
    phys_rx_i = 4'hF; log_tx_i = 4'hF; #1;
    chk("R10 rx gated", log_rx_o, 4'hA);
    chk("R11 tx gated idle", phys_tx_o, 4'h5);
  endtask

  task automatic t_bad_mask();
    do_reset();
    wr(4'h3, 8'h0A);
    wr(4'h3, 8'h10);
    chk("R3 err", err_o, 1);
    chk("R3 mask kept", sdi_mask_o, 8'h0A);
    step(); step();
    chk("R5 sticky", err_o, 1);
  endtask

  task automatic t_map();
    do_reset();
    wmap(3'd0, 3'd2);
    wmap(3'd2, 3'd0);
    chk("R4 map", map_o, 12'h60A);
    chk("R4 no err", err_o, 0);
    wr(4'h3, 8'h0F); wr(4'h4, 8'h0F);
    phys_rx_i = 4'b0100; log_tx_i = 4'b0001; #1;
    chk("R10 remap rx", log_rx_o, 4'b0001);
    chk("R11 remap tx", phys_tx_o, 4'b0100);
    wmap(3'd1, 3'd4);
    chk("R4 bad phys err", err_o, 1);
    chk("R4 bad phys kept", map_o, 12'h60A);
    wmap(3'd5, 3'd1);
    chk("R4 bad lane kept", map_o, 12'h60A);
    do_reset();
    wmap(3'd1, 3'd0);
    wr(4'h4, 8'h0F);
    log_tx_i = 4'b0010; #1;
    chk("R11 lowest wins / unmapped idle", phys_tx_o, 4'b0000);
    log_tx_i = 4'b0001; #1;
    chk("R11 lowest wins", phys_tx_o, 4'b0001);
  endtask

  task automatic t_stripe();
    do_reset();
    wmap(3'd0, 3'd1);
    wmap(3'd1, 3'd0);
    act_cnt_i = 3'd2;
    stripe_start_i = 1; step(); stripe_start_i = 0;
    chk("R8 start sdi", sdi_mask_o, 8'h03);
    chk("R8 start sdo", sdo_mask_o, 8'h03);
    stripe_end_i = 1; step(); stripe_end_i = 0;
    chk("R8 end sdi", sdi_mask_o, 8'h02);
    chk("R8 end sdo", sdo_mask_o, 8'h02);
    act_cnt_i = 3'd4;
    stripe_start_i = 1; step(); stripe_start_i = 0;
    chk("R8 start all", sdi_mask_o, 8'h0F);
  endtask

  task automatic t_setup();
    do_reset();
    wmap(3'd0, 3'd3);
    setup_i = 1; step(); setup_i = 0;
    chk("R9 sdi", sdi_mask_o, 8'h08);
    chk("R9 sdo", sdo_mask_o, 8'h08);
  endtask

  task automatic t_pending();
    do_reset();
    cs_active_i = 1;
    wr(4'h3, 8'h04);
    chk("R6 held", sdi_mask_o, 8'h01);
    wr(4'h3, 8'h06);
    chk("R6 still held", sdi_mask_o, 8'h01);
    cs_active_i = 0; step();
    chk("R6 applied latest", sdi_mask_o, 8'h06);
    cs_active_i = 1;
    wr(4'h4, 8'h02);
    chk("R6 sdo held", sdo_mask_o, 8'h01);
    cs_active_i = 0;
    wr(4'h4, 8'h08);
    chk("R7 new beats pending", sdo_mask_o, 8'h08);
    step();
    chk("R7 pending dropped", sdo_mask_o, 8'h08);
    cmd_wr_i = 1; cmd_reg_i = 4'h3; cmd_data_i = 8'h0C; stripe_end_i = 1;
    step();
    cmd_wr_i = 0; stripe_end_i = 0;
    chk("R7 cmd beats strobe", sdi_mask_o, 8'h0C);
    chk("R7 other mask strobe", sdo_mask_o, 8'h01);
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mask_write();
    t_bad_mask();
    t_map();
    t_stripe();
    t_setup();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule